// File: doc/BRIEF.md
# Gated Debug Mode Control Register

This block holds three debug control bits: a halting-mode enable, a monitor-mode enable and an enable for the instruction-transfer register. The bits are written through a plain register port. An external debug-enable input gates how they are seen. While that input is low, the two mode bits read back as zero and drive no effective mode. Their written values are still kept. The moment the input rises, readback and the effective mode outputs follow the kept values in the same cycle. Halting mode takes precedence over monitor mode.

The block also gates writes to the instruction-transfer register. A transfer write is accepted only when the transfer enable is set and the processor is in debug state. A rejected transfer write raises a one-cycle error pulse. The same pulse flags an attempt to set the transfer enable outside debug state. A save/restore port lets power-down logic capture and reload the programmed bits rather than the masked view.

Top module: `dbg_mode_ctl`

## Requirements
- R1: A synchronous active-low reset clears all three programmed bits to 0, so `save_bits` reads 3'b000 after the reset edge.
- R2: A register write (`wr_en` high) updates the programmed bits at the next rising clock edge. The monitor enable is taken from `wr_data` bit 15, the halting enable from bit 14 and the transfer enable from bit 13.
- R3: While `dbg_en` is low, `rd_data` bits 15 and 14 read 0, and both `halt_mode` and `mon_mode` are 0. The programmed values are kept.
- R4: While `dbg_en` is high, `rd_data` bits 15 and 14 equal the programmed monitor and halting bits in the same cycle, with no clock edge needed.
- R5: Whenever `halt_mode` is 1, `mon_mode` is 0. Otherwise `mon_mode` equals the programmed monitor bit ANDed with `dbg_en`.
- R6: `save_bits` always presents the unmasked programmed bits, whatever the value of `dbg_en`. Bit 2 is monitor, bit 1 is halting and bit 0 is transfer enable.
- R7: `restore_en` loads `restore_bits` (same encoding as `save_bits`) at the next edge. A restore overrides a register write in the same cycle, and that write is dropped.
- R8: `itr_accept` is high in the same cycle exactly when `itr_wr` is high, the programmed transfer enable is 1 and `in_debug` is 1.
- R9: A transfer write that is not accepted sets `itr_err` high for exactly the one cycle after it.
- R10: A register write that is not overridden by a restore, has bit 13 at 1 and happens while `in_debug` is 0 sets `itr_err` high for the one cycle after it.
- R11: `rd_data` bit 13 always shows the programmed transfer enable, and every `rd_data` bit other than 15, 14 and 13 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_en | input | 1 | External debug enable; masks the mode bits |
| in_debug | input | 1 | High while the processor is in debug state |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Masked register readback |
| restore_en | input | 1 | Load programmed bits from `restore_bits` |
| restore_bits | input | 3 | Bits to restore: {monitor, halting, transfer} |
| save_bits | output | 3 | Unmasked programmed bits: {monitor, halting, transfer} |
| halt_mode | output | 1 | Effective halting mode enable |
| mon_mode | output | 1 | Effective monitor mode enable |
| itr_wr | input | 1 | Write request to the instruction-transfer register |
| itr_accept | output | 1 | Transfer write accepted this cycle |
| itr_err | output | 1 | One-cycle error pulse |

## Verification
The bench sweeps every combination of the three programmed bits, `dbg_en` and `in_debug`. The critical case is the pattern with both mode bits set: a design that masked monitor mode by its own bit instead of by the effective halting bit would assert both modes at once. With `dbg_en` low, a design that cleared the stored bits instead of masking them would lose the settings, and this shows up on `save_bits` and after `dbg_en` rises again. The bench also drives a restore and a write in the same cycle, where the wrong priority loads the write data. It checks that the error pulse drops after one cycle, so a sticky error flag would be caught.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // Programmed debug control bits, packed as {monitor, halting, transfer}
    typedef struct packed {
        logic mon;
        logic halt;
        logic itr;
    } mode_bits_t;

    localparam int unsigned MODE_BITS_W = $bits(mode_bits_t);

endpackage

// File: rtl/dmc_prog_reg.sv
module dmc_prog_reg
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  mode_bits_t wr_bits,
    input  logic       restore_en,
    input  mode_bits_t restore_bits,
    output mode_bits_t prog_q
);

    typedef struct packed {
        mode_bits_t prog;
    } prog_state_t;

    prog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restore_en) begin
            st_d.prog = restore_bits;
        end else if (wr_en) begin
            st_d.prog = wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_q = st_q.prog;

endmodule

// File: rtl/dmc_mode_mask.sv
module dmc_mode_mask
    import dmc_pkg::*;
(
    input  mode_bits_t prog,
    input  logic       dbg_en,
    output mode_bits_t view,
    output logic       halt_eff,
    output logic       mon_eff
);

    always_comb begin
        view.mon  = prog.mon  & dbg_en;
        view.halt = prog.halt & dbg_en;
        view.itr  = prog.itr;
        halt_eff  = view.halt;
        // Halting mode wins over monitor mode
        mon_eff   = view.mon & ~view.halt;
    end

endmodule

// File: rtl/dmc_itr_gate.sv
module dmc_itr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic itr_en,
    input  logic in_debug,
    input  logic itr_wr,
    input  logic wr_en,
    input  logic wr_itr,
    input  logic restore_en,
    output logic itr_accept,
    output logic itr_err
);

    typedef struct packed {
        logic err;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        rejected;
    logic        bad_set;

    always_comb begin
        itr_accept = itr_wr & itr_en & in_debug;
        rejected   = itr_wr & ~itr_accept;
        bad_set    = wr_en & ~restore_en & wr_itr & ~in_debug;
        st_d.err   = rejected | bad_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign itr_err = st_q.err;

endmodule

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl
    import dmc_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MON_BIT  = 15,
    parameter int unsigned HALT_BIT = 14,
    parameter int unsigned ITR_BIT  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic              in_debug,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              restore_en,
    input  logic [2:0]        restore_bits,
    output logic [2:0]        save_bits,
    output logic              halt_mode,
    output logic              mon_mode,
    input  logic              itr_wr,
    output logic              itr_accept,
    output logic              itr_err
);

    mode_bits_t wr_bits;
    mode_bits_t rs_bits;
    mode_bits_t prog_q;
    mode_bits_t view;

    always_comb begin
        wr_bits.mon  = wr_data[MON_BIT];
        wr_bits.halt = wr_data[HALT_BIT];
        wr_bits.itr  = wr_data[ITR_BIT];
        rs_bits      = mode_bits_t'(restore_bits);
    end

    dmc_prog_reg u_prog (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_bits      (wr_bits),
        .restore_en   (restore_en),
        .restore_bits (rs_bits),
        .prog_q       (prog_q)
    );

    dmc_mode_mask u_mask (
        .prog     (prog_q),
        .dbg_en   (dbg_en),
        .view     (view),
        .halt_eff (halt_mode),
        .mon_eff  (mon_mode)
    );

    dmc_itr_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .itr_en     (prog_q.itr),
        .in_debug   (in_debug),
        .itr_wr     (itr_wr),
        .wr_en      (wr_en),
        .wr_itr     (wr_bits.itr),
        .restore_en (restore_en),
        .itr_accept (itr_accept),
        .itr_err    (itr_err)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[MON_BIT]  = view.mon;
        rd_data[HALT_BIT] = view.halt;
        rd_data[ITR_BIT]  = view.itr;
    end

    assign save_bits = prog_q;

endmodule

// File: rtl/dbg_mode_ctl_chk.sv
module dbg_mode_ctl_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MON_BIT  = 15,
    parameter int unsigned HALT_BIT = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_en,
    input logic              in_debug,
    input logic [DATA_W-1:0] rd_data,
    input logic              restore_en,
    input logic [2:0]        restore_bits,
    input logic [2:0]        save_bits,
    input logic              wr_en,
    input logic              halt_mode,
    input logic              mon_mode,
    input logic              itr_wr,
    input logic              itr_accept,
    input logic              itr_err
);

    // R3
    masked_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |-> (!rd_data[MON_BIT] && !rd_data[HALT_BIT] && !halt_mode && !mon_mode));

    // R5
    halt_over_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_mode |-> !mon_mode);

    // R6
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !restore_en) |=> $stable(save_bits));

    // R7
    restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> (save_bits == $past(restore_bits)));

    // R8
    accept_needs_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        itr_accept |-> (itr_wr && in_debug && save_bits[0]));

    // R9
    reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (itr_wr && !itr_accept) |=> itr_err);

endmodule

bind dbg_mode_ctl dbg_mode_ctl_chk #(
    .DATA_W   (DATA_W),
    .MON_BIT  (MON_BIT),
    .HALT_BIT (HALT_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_en       (dbg_en),
    .in_debug     (in_debug),
    .rd_data      (rd_data),
    .restore_en   (restore_en),
    .restore_bits (restore_bits),
    .save_bits    (save_bits),
    .wr_en        (wr_en),
    .halt_mode    (halt_mode),
    .mon_mode     (mon_mode),
    .itr_wr       (itr_wr),
    .itr_accept   (itr_accept),
    .itr_err      (itr_err)
);

// File: tb/dbg_mode_ctl_tb.sv
`timescale 1ns/1ps
module dbg_mode_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dbg_en;
    logic        in_debug;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        restore_en;
    logic [2:0]  restore_bits;
    logic [2:0]  save_bits;
    logic        halt_mode;
    logic        mon_mode;
    logic        itr_wr;
    logic        itr_accept;
    logic        itr_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dbg_mode_ctl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_en       (dbg_en),
        .in_debug     (in_debug),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .restore_en   (restore_en),
        .restore_bits (restore_bits),
        .save_bits    (save_bits),
        .halt_mode    (halt_mode),
        .mon_mode     (mon_mode),
        .itr_wr       (itr_wr),
        .itr_accept   (itr_accept),
        .itr_err      (itr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [2:0] p, input logic de);
        exp_rd = 32'h0;
        exp_rd[15] = p[2] & de;
        exp_rd[14] = p[1] & de;
        exp_rd[13] = p[0];
    endfunction

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dbg_en = 1'b0; in_debug = 1'b0; wr_en = 1'b0; wr_data = '0;
        restore_en = 1'b0; restore_bits = '0; itr_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        dbg_en = 1'b1;
        @(negedge clk);
        check("R1 save", {29'b0, save_bits}, 32'h0);
        check("R1 rd", rd_data, 32'h0);
        check("R1 err", {31'b0, itr_err}, 32'h0);

        // Full sweep: programmed bits x dbg_en x in_debug
        for (int p = 0; p < 8; p++) begin
            for (int de = 0; de < 2; de++) begin
                for (int dbgst = 0; dbgst < 2; dbgst++) begin
                    logic [2:0] pb;
                    logic acc;
                    pb = 3'(p);
                    in_debug = dbgst[0];
                    dbg_en   = de[0];
                    wr_en    = 1'b1;
                    wr_data  = (32'hA5A5_0F0F & ~32'h0000_E000) | (32'(pb) << 13);
                    @(negedge clk);
                    wr_en = 1'b0;
                    check("R2/R6 save", {29'b0, save_bits}, {29'b0, pb});
                    check("R10 err", {31'b0, itr_err}, {31'b0, pb[0] & ~dbgst[0]});
                    check("R3/R4/R11 rd", rd_data, exp_rd(pb, de[0]));
                    check("R3/R4 halt", {31'b0, halt_mode}, {31'b0, pb[1] & de[0]});
                    check("R5 mon", {31'b0, mon_mode}, {31'b0, pb[2] & de[0] & ~pb[1]});
                    itr_wr = 1'b1;
                    #1;
                    acc = pb[0] & dbgst[0];
                    check("R8 accept", {31'b0, itr_accept}, {31'b0, acc});
                    @(negedge clk);
                    itr_wr = 1'b0;
                    check("R9 err", {31'b0, itr_err}, {31'b0, ~acc});
                    @(negedge clk);
                    check("R9 pulse width", {31'b0, itr_err}, 32'h0);
                end
            end
        end

        // Masked values retained and reappear when dbg_en rises
        in_debug = 1'b1; dbg_en = 1'b0;
        wr_en = 1'b1; wr_data = 32'h0000_8000;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 masked rd", rd_data, 32'h0);
        check("R6 unmasked save", {29'b0, save_bits}, 32'h4);
        dbg_en = 1'b1;
        #1;
        check("R4 immediate rd", rd_data, 32'h0000_8000);
        check("R4 immediate mon", {31'b0, mon_mode}, 32'h1);

        // Restore beats write in the same cycle, and the dropped write raises no error
        @(negedge clk);
        in_debug = 1'b0;
        wr_en = 1'b1; wr_data = 32'h0000_2000;
        restore_en = 1'b1; restore_bits = 3'b110;
        @(negedge clk);
        wr_en = 1'b0; restore_en = 1'b0;
        check("R7 priority", {29'b0, save_bits}, 32'h6);
        check("R7/R10 no err", {31'b0, itr_err}, 32'h0);
        dbg_en = 1'b0;
        restore_en = 1'b1; restore_bits = 3'b011;
        @(negedge clk);
        restore_en = 1'b0;
        check("R7 restore masked", {29'b0, save_bits}, 32'h3);
        check("R3 rd after restore", rd_data, 32'h0000_2000);

        // Reset in the middle of operation
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset", {29'b0, save_bits}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule